// File: doc/BRIEF.md
# Stack machine opcode decoder

This block turns a stream of one-byte instructions for a 32-bit zero-operand stack processor into decoded operations. Each accepted byte yields, one cycle later, an operation class and a stack-relative word offset. It also gives a flag saying whether the executor must push a new stack entry, a break indication for breakpoint and undefined codes, and a flag choosing between a sequential program-counter step and a computed target. Executing the operation, performing memory accesses and keeping the stack pointer are all left to the executor that consumes these outputs.

Immediate instructions carry seven payload bits. The decoder remembers whether the last accepted instruction was an immediate. A run of immediate bytes therefore builds a single constant. The first byte of a run pushes a sign-extended value. Each later byte shifts the current top of stack, presented on `tos_in`, left by seven and appends its payload. The decoder returns the new top-of-stack value so the executor can write it back.

Top module: `stkop_decoder`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `out_valid`, `out_push`, `out_break`, `out_seq_pc`, `out_word_off` and `out_imm_value` are zero, and the immediate-run state is cleared.
- R2: Each cycle with `in_valid` high produces exactly one decoded operation with `out_valid` high on the following cycle. A cycle with `in_valid` low produces `out_valid` low with every other output zero, and leaves the immediate-run state unchanged.
- R3: A byte with bit 7 set that starts a run decodes as `OP_IMM` with `out_push` = 1 and `out_imm_value` = bits 6:0 sign-extended from bit 6 to 32 bits.
- R4: A byte with bit 7 set that follows an immediate decodes as `OP_IMM` with `out_push` = 0 and `out_imm_value` = (`tos_in` << 7) | bits 6:0, truncated to 32 bits.
- R5: Any accepted byte with bit 7 clear ends the run, so the next immediate starts a new one. Cycles with `in_valid` low do not end a run.
- R6: Bytes 0x60–0x7F decode as `OP_LOADSP` and 0x40–0x5F as `OP_STORESP`, with `out_word_off` = bits 4:0 XOR 0x10 (byte offset is this value × 4).
- R7: Bytes 0x11–0x1F decode as `OP_ADDSP` with `out_word_off` = bits 3:0. Byte 0x10 decodes as `OP_DOUBLE` (top of stack added to itself) with offset 0.
- R8: 0x00 `OP_BREAK`, 0x02 `OP_PUSHSP`, 0x04 `OP_POPPC`, 0x05 `OP_ADD`, 0x06 `OP_AND`, 0x07 `OP_OR`, 0x08 `OP_LOAD`, 0x09 `OP_NOT`, 0x0A `OP_FLIP`, 0x0B `OP_NOP`, 0x0C `OP_STORE`, 0x0D `OP_POPSP`.
- R9: Bytes 0x22 up to 0x3F decode, in rising order, as `OP_LOADH`, `OP_STOREH`, `OP_LTS`, `OP_LES`, `OP_LTU`, `OP_LEU`, `OP_SWAPH`, `OP_MUL`, `OP_SHRL`, `OP_SHL`, `OP_SHRA`, `OP_CALL`, `OP_EQ`, `OP_NE`, `OP_NEG`, `OP_SUB`, `OP_XOR`, `OP_LOADB`, `OP_STOREB`, `OP_DIV`, `OP_MOD`, `OP_BRZ`, `OP_BRNZ`, `OP_POPPCREL`, `OP_CONFIG`, `OP_PUSHPC`, `OP_SYSCALL`, `OP_PUSHSPADD`, `OP_MUL16`, `OP_CALLREL`.
- R10: Bytes 0x01, 0x03, 0x0E, 0x0F, 0x20 and 0x21 decode as `OP_ILLEGAL`. `out_break` is 1 exactly for `OP_ILLEGAL` and `OP_BREAK`.
- R11: `out_seq_pc` is 0 for `OP_POPPC`, `OP_POPPCREL`, `OP_CALL`, `OP_CALLREL`, `OP_BRZ` and `OP_BRNZ`, which take a computed target. It is 1 for every other valid operation.
- R12: `out_push` is 1 for `OP_PUSHSP`, `OP_PUSHPC`, `OP_LOADSP` and the first immediate of a run, and 0 otherwise. `out_word_off` and `out_imm_value` are 0 for operations that do not define them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction byte strobe |
| in_byte | input | 8 | Fetched instruction byte |
| tos_in | input | DATA_W | Current top of stack, used when chaining immediates |
| out_valid | output | 1 | Decoded operation present |
| out_op | output | 6 | Operation class (`op_e` from the package) |
| out_word_off | output | 5 | Word offset from the stack pointer |
| out_imm_value | output | DATA_W | New top-of-stack value for immediates |
| out_push | output | 1 | Executor must push a new stack entry |
| out_break | output | 1 | Breakpoint or undefined opcode |
| out_seq_pc | output | 1 | 1: advance PC by one; 0: computed target |

## Verification
The bench builds the decoder with its default 32-bit data width. With that width, a run of five or more immediate bytes shifts payload bits out of the top of the word, so truncation is reached. A payload with bit 6 set exercises sign extension across 25 upper bits. Every one of the 128 non-immediate codes is swept once. A long random stretch with gaps in the strobe then checks that idle cycles neither emit operations nor break an immediate run.

// File: rtl/stkop_pkg.sv
package stkop_pkg;
  localparam int OPC_W   = 6;
  localparam int OFF_W   = 5;
  localparam int IMM_W   = 7;
  localparam int BYTE_W  = 8;
  localparam logic [OFF_W-1:0] OFF_FLIP = 5'h10;

  typedef enum logic [OPC_W-1:0] {
    OP_BREAK, OP_ILLEGAL, OP_PUSHSP, OP_POPPC, OP_ADD, OP_AND, OP_OR,
    OP_LOAD, OP_NOT, OP_FLIP, OP_NOP, OP_STORE, OP_POPSP, OP_ADDSP,
    OP_DOUBLE, OP_LOADSP, OP_STORESP, OP_IMM,
    OP_LOADH, OP_STOREH, OP_LTS, OP_LES, OP_LTU, OP_LEU, OP_SWAPH,
    OP_MUL, OP_SHRL, OP_SHL, OP_SHRA, OP_CALL, OP_EQ, OP_NE, OP_NEG,
    OP_SUB, OP_XOR, OP_LOADB, OP_STOREB, OP_DIV, OP_MOD, OP_BRZ,
    OP_BRNZ, OP_POPPCREL, OP_CONFIG, OP_PUSHPC, OP_SYSCALL,
    OP_PUSHSPADD, OP_MUL16, OP_CALLREL
  } op_e;

  typedef struct packed {
    op_e              op;
    logic [OFF_W-1:0] word_off;
    logic             brk;
    logic             seq_pc;
    logic             push_fixed;
  } dec_t;
endpackage

// File: rtl/stkop_classify.sv
module stkop_classify
  import stkop_pkg::*;
(
  input  logic [BYTE_W-1:0] code,
  output dec_t              dec
);
  localparam int GRP_BASE = 2;

  logic [OPC_W-1:0] grp_idx;
  op_e              op_c;
  logic [OFF_W-1:0] off_c;

  assign grp_idx = OPC_W'(OP_LOADH) + {1'b0, code[4:0]} - OPC_W'(GRP_BASE);

  always_comb begin
    op_c  = OP_ILLEGAL;
    off_c = '0;
    if (code[7]) begin
      op_c = OP_IMM;
    end else if (code[6:5] == 2'b11) begin
      op_c  = OP_LOADSP;
      off_c = code[4:0] ^ OFF_FLIP;
    end else if (code[6:5] == 2'b10) begin
      op_c  = OP_STORESP;
      off_c = code[4:0] ^ OFF_FLIP;
    end else if (code[6:4] == 3'b001) begin
      op_c  = (code[3:0] == 4'd0) ? OP_DOUBLE : OP_ADDSP;
      off_c = {1'b0, code[3:0]};
    end else if (code[6:5] == 2'b01) begin
      op_c = (code[4:0] >= 5'(GRP_BASE)) ? op_e'(grp_idx) : OP_ILLEGAL;
    end else begin
      case (code[3:0])
        4'h0:    op_c = OP_BREAK;
        4'h2:    op_c = OP_PUSHSP;
        4'h4:    op_c = OP_POPPC;
        4'h5:    op_c = OP_ADD;
        4'h6:    op_c = OP_AND;
        4'h7:    op_c = OP_OR;
        4'h8:    op_c = OP_LOAD;
        4'h9:    op_c = OP_NOT;
        4'hA:    op_c = OP_FLIP;
        4'hB:    op_c = OP_NOP;
        4'hC:    op_c = OP_STORE;
        4'hD:    op_c = OP_POPSP;
        default: op_c = OP_ILLEGAL;
      endcase
    end
  end

  always_comb begin
    dec.op         = op_c;
    dec.word_off   = off_c;
    dec.brk        = (op_c == OP_BREAK) || (op_c == OP_ILLEGAL);
    dec.seq_pc     = !(op_c inside {OP_POPPC, OP_POPPCREL, OP_CALL,
                                    OP_CALLREL, OP_BRZ, OP_BRNZ});
    dec.push_fixed = op_c inside {OP_PUSHSP, OP_PUSHPC, OP_LOADSP};
  end
endmodule

// File: rtl/stkop_imm.sv
module stkop_imm
  import stkop_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_is_imm,
  input  logic [IMM_W-1:0]  payload,
  input  logic [DATA_W-1:0] tos_in,
  output logic              run_q,
  output logic              first,
  output logic [DATA_W-1:0] value
);
  localparam int EXT_W = DATA_W - IMM_W;

  assign first = !run_q;
  assign value = run_q ? {tos_in[EXT_W-1:0], payload}
                       : {{EXT_W{payload[IMM_W-1]}}, payload};

  always_ff @(posedge clk) begin
    if (rst)           run_q <= 1'b0;
    else if (in_valid) run_q <= in_is_imm;
  end

  assert_run_ends_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_is_imm) |=> !run_q);
  assert_gap_keeps_R5: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> run_q == $past(run_q));
endmodule

// File: rtl/stkop_decoder.sv
module stkop_decoder
  import stkop_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  input  logic [DATA_W-1:0] tos_in,
  output logic              out_valid,
  output logic [5:0]        out_op,
  output logic [4:0]        out_word_off,
  output logic [DATA_W-1:0] out_imm_value,
  output logic              out_push,
  output logic              out_break,
  output logic              out_seq_pc
);
  dec_t              dec;
  logic              run_q;
  logic              imm_first;
  logic [DATA_W-1:0] imm_val;
  logic              is_imm;

  assign is_imm = in_byte[BYTE_W-1];

  stkop_classify u_cls (
    .code (in_byte),
    .dec  (dec)
  );

  stkop_imm #(.DATA_W(DATA_W)) u_imm (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_is_imm (is_imm),
    .payload   (in_byte[IMM_W-1:0]),
    .tos_in    (tos_in),
    .run_q     (run_q),
    .first     (imm_first),
    .value     (imm_val)
  );

  always_ff @(posedge clk) begin
    if (rst || !in_valid) begin
      out_valid     <= 1'b0;
      out_op        <= '0;
      out_word_off  <= '0;
      out_imm_value <= '0;
      out_push      <= 1'b0;
      out_break     <= 1'b0;
      out_seq_pc    <= 1'b0;
    end else begin
      out_valid     <= 1'b1;
      out_op        <= dec.op;
      out_word_off  <= dec.word_off;
      out_imm_value <= is_imm ? imm_val : '0;
      out_push      <= dec.push_fixed | (is_imm & imm_first);
      out_break     <= dec.brk;
      out_seq_pc    <= dec.seq_pc;
    end
  end

  assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_push && !out_break));
  assert_first_push_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_op == OP_IMM) |-> (out_push == !$past(run_q)));
  assert_sext_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_op == OP_IMM && out_push) |->
      ($countones(out_imm_value[DATA_W-1:IMM_W-1]) == 0 ||
       $countones(out_imm_value[DATA_W-1:IMM_W-1]) == DATA_W-IMM_W+1));
  assert_break_R10: assert property (@(posedge clk) disable iff (rst)
    out_break |-> (out_valid && (out_op == OP_BREAK || out_op == OP_ILLEGAL)));
  assert_flow_R11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_seq_pc) |->
      (out_op inside {OP_POPPC, OP_POPPCREL, OP_CALL, OP_CALLREL, OP_BRZ, OP_BRNZ}));
  assert_loadsp_push_R12: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_op == OP_LOADSP) |-> out_push);
endmodule

// File: tb/stkop_decoder_tb.sv
module stkop_decoder_tb;
  import stkop_pkg::*;

  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [7:0]    in_byte = '0;
  logic [DW-1:0] tos_in = '0;
  logic          out_valid, out_push, out_break, out_seq_pc;
  logic [5:0]    out_op;
  logic [4:0]    out_word_off;
  logic [DW-1:0] out_imm_value;

  int n_checks = 0;
  int n_fail   = 0;

  bit            run_m = 0;
  logic          e_valid = 0, e_push = 0, e_brk = 0, e_seq = 0;
  logic [5:0]    e_op = '0;
  logic [4:0]    e_off = '0;
  logic [DW-1:0] e_imm = '0;
  string         e_tag = "R1";

  always #5 clk = ~clk;

  stkop_decoder #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .tos_in(tos_in), .out_valid(out_valid), .out_op(out_op),
    .out_word_off(out_word_off), .out_imm_value(out_imm_value),
    .out_push(out_push), .out_break(out_break), .out_seq_pc(out_seq_pc)
  );

  op_e mid_tbl [30] = '{OP_LOADH, OP_STOREH, OP_LTS, OP_LES, OP_LTU, OP_LEU,
    OP_SWAPH, OP_MUL, OP_SHRL, OP_SHL, OP_SHRA, OP_CALL, OP_EQ, OP_NE, OP_NEG,
    OP_SUB, OP_XOR, OP_LOADB, OP_STOREB, OP_DIV, OP_MOD, OP_BRZ, OP_BRNZ,
    OP_POPPCREL, OP_CONFIG, OP_PUSHPC, OP_SYSCALL, OP_PUSHSPADD, OP_MUL16, OP_CALLREL};

  task automatic chk(input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2", "valid", DW'(out_valid), DW'(e_valid));
    chk(e_tag, "op", DW'(out_op), DW'(e_op));
    chk(e_tag, "offset", DW'(out_word_off), DW'(e_off));
    chk(e_tag, "imm", out_imm_value, e_imm);
    chk("R12", "push", DW'(out_push), DW'(e_push));
    chk("R10", "break", DW'(out_break), DW'(e_brk));
    chk("R11", "seqpc", DW'(out_seq_pc), DW'(e_seq));
  endtask

  // Reference model: expectation for the byte presented this cycle
  task automatic model(input logic v, input logic [7:0] b, input logic [DW-1:0] t);
    int   ub;
    op_e  op;
    ub = int'(b);
    e_valid = v; e_op = '0; e_off = '0; e_imm = '0;
    e_push = 0; e_brk = 0; e_seq = 0; e_tag = "R2";
    if (!v) return;
    e_push = 0;
    if (ub >= 128) begin
      op = OP_IMM;
      if (run_m) begin
        e_imm = (t << 7) | DW'(ub % 128); e_tag = "R4";
      end else begin
        e_imm = (ub % 128 >= 64) ? DW'(ub % 128) - DW'(128) : DW'(ub % 128);
        e_push = 1; e_tag = "R3";
      end
      run_m = 1;
    end else begin
      run_m = 0;
      if (ub >= 96) begin op = OP_LOADSP; e_off = 5'((ub - 96) ^ 16); e_tag = "R6"; end
      else if (ub >= 64) begin op = OP_STORESP; e_off = 5'((ub - 64) ^ 16); e_tag = "R6"; end
      else if (ub >= 34) begin op = mid_tbl[ub - 34]; e_tag = "R9"; end
      else if (ub >= 32) begin op = OP_ILLEGAL; e_tag = "R10"; end
      else if (ub == 16) begin op = OP_DOUBLE; e_tag = "R7"; end
      else if (ub > 16) begin op = OP_ADDSP; e_off = 5'(ub - 16); e_tag = "R7"; end
      else begin
        e_tag = "R8";
        case (ub)
          0: op = OP_BREAK;   2: op = OP_PUSHSP; 4: op = OP_POPPC;
          5: op = OP_ADD;     6: op = OP_AND;    7: op = OP_OR;
          8: op = OP_LOAD;    9: op = OP_NOT;    10: op = OP_FLIP;
          11: op = OP_NOP;    12: op = OP_STORE; 13: op = OP_POPSP;
          default: begin op = OP_ILLEGAL; e_tag = "R10"; end
        endcase
      end
      if (op == OP_PUSHSP || op == OP_PUSHPC || op == OP_LOADSP) e_push = 1;
    end
    e_op  = 6'(op);
    e_brk = (op == OP_BREAK || op == OP_ILLEGAL);
    e_seq = !(op == OP_POPPC || op == OP_POPPCREL || op == OP_CALL ||
              op == OP_CALLREL || op == OP_BRZ || op == OP_BRNZ);
  endtask

  // Checks the previous cycle's result, then presents a new byte
  task automatic step(input logic v, input logic [7:0] b);
    logic [DW-1:0] t;
    @(negedge clk);
    compare_all();
    t = $urandom();
    in_valid = v; in_byte = b; tos_in = t;
    model(v, b, t);
  endtask

  initial begin
    #(200000 * 10);
    n_checks++; n_fail++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state, outputs all zero
    e_tag = "R1";
    compare_all();
    rst = 1'b0;
    model(1'b0, 8'h00, '0);
    // Sweep every non-immediate code (R6..R12)
    for (int i = 0; i < 128; i++) step(1'b1, 8'(i));
    // R3 negative first immediate, R4 chaining, R5 gap keeps run
    step(1'b1, 8'hC0);
    step(1'b1, 8'h85);
    step(1'b0, 8'h0B);
    step(1'b1, 8'h81);
    step(1'b1, 8'h0B);   // R5: non-immediate ends the run
    step(1'b1, 8'h81);   // R3: positive first again
    for (int i = 0; i < 6; i++) step(1'b1, 8'hFF);  // R4 long run truncation
    step(1'b1, 8'h60);
    step(1'b1, 8'hBF);   // R3 after load
    // Random stretch with strobe gaps
    for (int i = 0; i < 4000; i++)
      step(1'($urandom_range(0, 3) != 0),
           ($urandom_range(0, 1) != 0) ? (8'h80 | 8'($urandom())) : 8'($urandom()));
    step(1'b0, 8'h00);
    step(1'b0, 8'h00);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule